// File: doc/BRIEF.md
# Source-Synchronous Serializer with Forwarded Clock

This transmitter turns J-bit parallel words into serial bit streams on a fast bit clock, one stream per data lane. A parallel word is taken in on a one-cycle load strobe, which the surrounding logic raises once every J bit-clock cycles, in step with the slow word clock. Each lane then shifts its word out, most significant bit first. Clock multiplication, pads and receivers sit outside this block.

The block also makes a forwarded clock for the receiver. An extra lane, built from the same serializer, reloads a fixed bit pattern instead of data on every strobe. Its output is therefore a divided copy of the bit clock. The pattern is picked from J and a divide-select code. A static centre-align option passes the clock lane alone through a flop clocked on the falling edge. This moves the forwarded clock half a bit period later, so its edges fall in the middle of the data eye.

Top module: `ser_fwd_tx`

## Requirements
- R1: While reset is high, and after it until the first load strobe, every `tx_data` bit and `tx_clk` read 0, in both centre-align settings.
- R2: After the rising edge at which `load` is high, each data lane presents its word one bit per cycle, MSB first. The first bit appears right after that edge.
- R3: Lane n serializes `din[n*J +: J]` and no other bits; the lanes are independent.
- R4: A strobe raised during the last bit of a word gives a gap-free stream: the next word's MSB follows that last bit directly.
- R5: If no new strobe comes, every lane (including the forwarded clock) drives 0 once the J bits of the word have been sent.
- R6: Clock-lane patterns, sent MSB first: `div_sel` 0 (divide by 2) gives 1010… for every J; code 1 (divide by 4) gives 0011 for J=4 and 00110011 for J=8.
- R7: With J=8, `div_sel` 1 gives the clock pattern 00110011.
- R8: With J=8, `div_sel` 2 (divide by 8) gives 11000011. With J=10, `div_sel` 3 (divide by 10) gives 1110000011.
- R9: A code that is not legal for the configured J falls back to the divide-by-2 pattern. Legal codes: J=4 {0,1}; J=8 {0,1,2}; J=10 {0,3}.
- R10: `div_sel` is sampled only at the load strobe. Changing it in the middle of a word does not alter the pattern being sent.
- R11: With `center_en`=1, `tx_clk` changes only on falling edges and carries the clock-lane bit half a cycle late. The data lanes keep their rising-edge timing.
- R12: With `center_en`=0, `tx_clk` changes on rising edges in step with the data lanes and holds its value for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle strobe that loads a new word and a new clock pattern |
| center_en | input | 1 | Static option: retime the forwarded clock on the falling edge |
| div_sel | input | 2 | Forwarded-clock divide code (0:/2, 1:/4, 2:/8, 3:/10) |
| din | input | LANES*J | Parallel words; lane n uses bits n*J+J-1 down to n*J |
| tx_data | output | LANES | Serial data, one bit per lane |
| tx_clk | output | 1 | Forwarded clock lane |

## Verification
The data lanes are driven with asymmetric bytes such as A5/3C and all-ones/all-zeros pairs. A bit-order swap, a lane swap or a wrong slice of `din` therefore gives a visibly different stream. The clock lane is run with every J=8 pattern and with an illegal code. Because each pattern has a different first bit and run length, a wrong pattern choice or a missing fallback shows up. Back-to-back words separate a correct reload from one that inserts a gap or drops a bit. The forwarded clock is sampled both before and after the falling edge, which separates direct output from the half-cycle-retimed output.

// File: rtl/ser_fwd_pkg.sv
`timescale 1ns/1ps
package ser_fwd_pkg;

  typedef enum logic [1:0] {
    DIV_BY_2  = 2'd0,
    DIV_BY_4  = 2'd1,
    DIV_BY_8  = 2'd2,
    DIV_BY_10 = 2'd3
  } div_code_e;

  // Whether a divide code is supported for serialization factor j
  function automatic logic div_is_legal(input int j, input div_code_e c);
    case (c)
      DIV_BY_2:  return 1'b1;
      DIV_BY_4:  return (j == 4) || (j == 8);
      DIV_BY_8:  return (j == 8);
      DIV_BY_10: return (j == 10);
      default:   return 1'b0;
    endcase
  endfunction

  // Bit i (0 = first sent) of the forwarded-clock pattern
  function automatic logic pattern_bit(input div_code_e c, input int i);
    case (c)
      DIV_BY_2:  return ((i % 2) == 0);
      DIV_BY_4:  return (((i / 2) % 2) == 1);
      DIV_BY_8:  return ((((i + 2) / 4) % 2) == 0);
      DIV_BY_10: return ((((i + 2) / 5) % 2) == 0);
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ser_clk_pattern.sv
`timescale 1ns/1ps
module ser_clk_pattern #(
  parameter int J = 8
) (
  input  logic [1:0]   div_sel,
  output logic [J-1:0] pattern
);
  import ser_fwd_pkg::*;

  div_code_e eff_code;

  always_comb begin
    eff_code = div_code_e'(div_sel);
    if (!div_is_legal(J, eff_code)) eff_code = DIV_BY_2;
    for (int i = 0; i < J; i++) begin
      pattern[J-1-i] = pattern_bit(eff_code, i);
    end
  end

endmodule

// File: rtl/ser_lane.sv
`timescale 1ns/1ps
module ser_lane #(
  parameter int J      = 8,
  parameter bit RETIME = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [J-1:0] word,
  input  logic         center_en,
  output logic         ser_out
);

  logic [J-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {shreg[J-2:0], 1'b0};
  end

  generate
    if (RETIME) begin : g_retime
      logic fall_q;
      always_ff @(negedge clk) begin
        if (rst) fall_q <= 1'b0;
        else     fall_q <= shreg[J-1];
      end
      assign ser_out = center_en ? fall_q : shreg[J-1];
    end else begin : g_bypass
      logic unused_cen;
      assign unused_cen = center_en;
      assign ser_out    = shreg[J-1];
    end
  endgenerate

endmodule

// File: rtl/ser_fwd_tx.sv
`timescale 1ns/1ps
module ser_fwd_tx #(
  parameter int LANES = 2,
  parameter int J     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               center_en,
  input  logic [1:0]         div_sel,
  input  logic [LANES*J-1:0] din,
  output logic [LANES-1:0]   tx_data,
  output logic               tx_clk
);

  logic [J-1:0] clk_pattern;

  ser_clk_pattern #(.J(J)) i_pattern (
    .div_sel (div_sel),
    .pattern (clk_pattern)
  );

  genvar n;
  generate
    for (n = 0; n < LANES; n++) begin : g_lane
      ser_lane #(.J(J), .RETIME(1'b0)) i_lane (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .word      (din[n*J +: J]),
        .center_en (1'b0),
        .ser_out   (tx_data[n])
      );
    end
  endgenerate

  ser_lane #(.J(J), .RETIME(1'b1)) i_clk_lane (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .word      (clk_pattern),
    .center_en (center_en),
    .ser_out   (tx_clk)
  );

endmodule

// File: rtl/ser_fwd_tx_chk.sv
`timescale 1ns/1ps
module ser_fwd_tx_chk #(
  parameter int LANES = 2,
  parameter int J     = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic               center_en,
  input logic [1:0]         div_sel,
  input logic [LANES*J-1:0] din,
  input logic [LANES-1:0]   tx_data,
  input logic               tx_clk
);
  localparam int CW = $clog2(J + 2);
  localparam logic [CW-1:0] LIM = CW'(J);

  logic          seen;
  logic [CW-1:0] since;
  logic [LANES-1:0] din_msb;

  genvar n;
  generate
    for (n = 0; n < LANES; n++) begin : g_msb
      assign din_msb[n] = din[n*J + J - 1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      since <= '0;
    end else begin
      if (load) seen <= 1'b1;
      if (load)              since <= CW'(1);
      else if (since <= LIM) since <= since + 1'b1;
    end
  end

  // R1: quiet until the first strobe
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (tx_data == '0 && !tx_clk));

  // R2: MSB of each lane comes out right after the strobe
  a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (tx_data == $past(din_msb)));

  // R5: lanes return to zero after the word is exhausted
  a_r5_drain_zero: assert property (@(posedge clk) disable iff (rst)
    (seen && since > LIM) |-> (tx_data == '0));

  // R6: divide-by-2 pattern starts high
  a_r6_div2_first_high: assert property (@(posedge clk) disable iff (rst)
    (load && !center_en && div_sel == 2'd0) |=> tx_clk);

  // R7: divide-by-4 pattern starts low where it is legal
  a_r7_div4_first_low: assert property (@(posedge clk) disable iff (rst)
    (load && !center_en && div_sel == 2'd1 && J != 10) |=> !tx_clk);

endmodule

bind ser_fwd_tx ser_fwd_tx_chk #(.LANES(LANES), .J(J)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .center_en (center_en),
  .div_sel   (div_sel),
  .din       (din),
  .tx_data   (tx_data),
  .tx_clk    (tx_clk)
);

// File: tb/test_ser_fwd_tx.sv
`timescale 1ns/1ps
module test_ser_fwd_tx;
  localparam int LANES = 2;
  localparam int J     = 8;
  localparam int DW    = LANES * J;

  logic             clk;
  logic             rst;
  logic             load;
  logic             center_en;
  logic [1:0]       div_sel;
  logic [DW-1:0]    din;
  logic [LANES-1:0] tx_data;
  logic             tx_clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  ser_fwd_tx #(.LANES(LANES), .J(J)) i_ser_fwd_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .center_en (center_en),
    .div_sel   (div_sel),
    .din       (din),
    .tx_data   (tx_data),
    .tx_clk    (tx_clk)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_bit(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s tx_clk: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_vec(input logic [LANES-1:0] act, input logic [LANES-1:0] exp,
                         input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s tx_data: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Reset with a given centre-align setting, then confirm idle zeros (R1)
  task automatic do_reset(input logic cen);
    center_en = cen;
    rst = 1'b1; load = 1'b0; din = '0; div_sel = 2'd0;
    repeat (3) @(posedge clk);
    #5;
    chk_vec(tx_data, '0, "R1 in reset");
    chk_bit(tx_clk, 1'b0, "R1 in reset");
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #5;
      chk_vec(tx_data, '0, "R1");
      chk_bit(tx_clk, 1'b0, "R1");
      #10;
      chk_bit(tx_clk, 1'b0, "R1 after fall");
    end
  endtask

  // Load one word and check every bit; returns at +15 ns of its last bit cycle
  task automatic send_word(input logic [DW-1:0] w, input logic [1:0] dsel,
                           input logic [J-1:0] expc, input string req,
                           input logic mid_en, input logic [1:0] mid_sel);
    logic [LANES-1:0] e;
    din = w; div_sel = dsel; load = 1'b1;
    @(posedge clk); #5;
    load = 1'b0;
    din  = ~w;
    for (int i = 0; i < J; i++) begin
      for (int n = 0; n < LANES; n++) e[n] = w[n*J + J - 1 - i];
      chk_vec(tx_data, e, req);
      if (center_en) begin
        if (i > 0) chk_bit(tx_clk, expc[J-i], "R11 before fall");
        #10;
        chk_bit(tx_clk, expc[J-1-i], "R11 after fall");
      end else begin
        chk_bit(tx_clk, expc[J-1-i], req);
        #10;
        chk_bit(tx_clk, expc[J-1-i], "R12 held");
      end
      if (mid_en && i == 2) div_sel = mid_sel;
      if (i < J - 1) begin
        @(posedge clk); #5;
      end
    end
  endtask

  task automatic check_drain();
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #5;
      chk_vec(tx_data, '0, "R5");
      if (!center_en) chk_bit(tx_clk, 1'b0, "R5");
      #10;
      chk_bit(tx_clk, 1'b0, "R5 after fall");
    end
  endtask

  task automatic t_single_word();
    send_word({8'h3C, 8'hA5}, 2'd0, 8'b10101010, "R2 R3 R6", 1'b0, 2'd0);
    check_drain();
  endtask

  task automatic t_lanes();
    send_word({8'h00, 8'hFF}, 2'd0, 8'b10101010, "R3 lane0 ones", 1'b0, 2'd0);
    send_word({8'hFF, 8'h00}, 2'd0, 8'b10101010, "R3 lane1 ones", 1'b0, 2'd0);
    check_drain();
  endtask

  task automatic t_back_to_back();
    send_word({8'h81, 8'h7E}, 2'd1, 8'b00110011, "R4 R7", 1'b0, 2'd0);
    send_word({8'hC3, 8'h18}, 2'd2, 8'b11000011, "R4 R8", 1'b0, 2'd0);
    send_word({8'h55, 8'h96}, 2'd0, 8'b10101010, "R4 R6", 1'b0, 2'd0);
    check_drain();
  endtask

  task automatic t_illegal();
    send_word({8'h0F, 8'hF0}, 2'd3, 8'b10101010, "R9", 1'b0, 2'd0);
    check_drain();
  endtask

  task automatic t_mid_change();
    send_word({8'h5A, 8'h33}, 2'd1, 8'b00110011, "R10", 1'b1, 2'd2);
    check_drain();
  endtask

  task automatic t_center();
    do_reset(1'b1);
    send_word({8'hA5, 8'h3C}, 2'd0, 8'b10101010, "R2 R11 data", 1'b0, 2'd0);
    send_word({8'h96, 8'h69}, 2'd2, 8'b11000011, "R4 R11 data", 1'b0, 2'd0);
    check_drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    t_single_word();
    t_lanes();
    t_back_to_back();
    t_illegal();
    t_mid_change();
    t_center();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule